// File: doc/BRIEF.md
# Winding Chopper Decay Controller

This block sequences the constant-current chopping of one stepper-motor winding. A chop cycle starts in charge. A current comparator (the trip input) reports when the winding current has reached its set value. After a short blanking window the block leaves charge and enters a decay phase, and it stays there until the cycle ends. Four decay policies are available: slow only, fast only, mixed and adaptive. In mixed decay the slow phase turns to fast at a programmable point in the cycle. In adaptive decay, charge or fast can be stretched across a cycle boundary. A second comparator input (the band input) tells the adaptive policy whether the current is still above the lower decay threshold.

The block drives the four gate enables of one H-bridge and reports its current phase. A one-clock all-off gap is placed between any two gate patterns where one transistor switches off while another switches on. All settings (decay policy, chop rate, mixed-decay point, blanking length and current direction) are sampled only at the start of a chop cycle. A setting changed mid-cycle therefore applies from the next cycle. When `run_i` is low, all gates are off and the cycle counter is held.

Top module: `chop_decay_ctrl`

## Requirements
- R1: The chop cycle lasts 16, 32 or 24 clocks for chop-rate code 00, 01 or 10, with the default base length of 16. The reserved code 11 behaves as 00. `cyc_start_o` is high in the first clock of every cycle.
- R2: `phase_o` reports 00 off, 01 charge, 10 slow and 11 fast. Outside adaptive mode, every cycle starts in charge, and a decay phase never returns to charge before the next cycle start.
- R3: Blanking: the trip input is ignored during the first B clocks of a charge. B is 2, 3, 4 or 6 for blanking code 00, 01, 10 or 11. With trip held high, charge lasts exactly B clocks.
- R4: Decay code 01 (slow only) goes from charge to slow for the rest of the cycle. Decay code 10 (fast only) goes from charge to fast for the rest of the cycle.
- R5: Decay code 00 (mixed): decay is slow until cycle count P = L*k/8 and fast from count P onward. L is the cycle length and k is 3, 4, 2 or 1 for mixed-point code 00, 01, 10 or 11. A trip honoured at or after count P enters fast directly.
- R6: Decay code 11 (adaptive): if no trip is honoured by the end of a cycle, charge continues through the boundary without a new blanking window. The first honoured trip enters fast.
- R7: Adaptive mode: fast continues through a cycle boundary while the band input is high. Fast turns to slow on the clock after the band input is seen low.
- R8: `gate_o` bits [3:0] are high-left, high-right, low-left, low-right. With direction 0: charge is 1001, slow 0011, fast 0110. With direction 1: charge is 0110, fast 1001, slow 0011. `gate_o` follows `phase_o` one clock later.
- R9: A change between two patterns in which one gate turns off and another turns on passes through exactly one clock of 0000. Changes from or to 0000 are direct.
- R10: Settings changed during a cycle take effect only at the next cycle start.
- R11: While `run_i` is low, `gate_o` is 0000, `phase_o` is off and `cyc_start_o` is low. On the clock after `run_i` rises, a cycle starts in charge.
- R12: The high and low gate of the same leg are never on together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Chopper oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Output enabled and not in standby |
| dir_i | input | 1 | Current direction, 0 forward, 1 reverse |
| trip_i | input | 1 | Current has reached the set value |
| band_i | input | 1 | Current still above the adaptive decay threshold |
| decay_i | input | 2 | Decay policy: 00 mixed, 01 slow, 10 fast, 11 adaptive |
| rate_i | input | 2 | Chop-rate code |
| mdt_i | input | 2 | Mixed-decay fast start point code |
| blank_i | input | 2 | Blanking length code |
| gate_o | output | 4 | H-bridge gate enables |
| phase_o | output | 2 | Current phase |
| cyc_start_o | output | 1 | First clock of a chop cycle |

## Verification
A corrupted phase register appears on `phase_o` in the same clock. The gate enables follow it one clock later, as a wrong pattern or a missing or extra dead clock. A cycle counter that is off shows up as `cyc_start_o` pulses at the wrong spacing. This is visible within one cycle length, at most 32 clocks. Blanking and mixed-point faults shift the clock at which charge or slow ends, and the bench counts that clock against the computed value. A wrong latch point for settings appears only one cycle later, as a cycle length or policy that changes too early.

// File: rtl/chop_pkg.sv
`timescale 1ns/1ps
package chop_pkg;

   localparam int GATE_W = 4;

   typedef enum logic [1:0] {
      PH_OFF  = 2'b00,
      PH_CHG  = 2'b01,
      PH_SLOW = 2'b10,
      PH_FAST = 2'b11
   } phase_e;

   typedef enum logic [1:0] {
      DM_MIXED = 2'b00,
      DM_SLOW  = 2'b01,
      DM_FAST  = 2'b10,
      DM_AUTO  = 2'b11
   } decay_e;

   // gate order: {high-left, high-right, low-left, low-right}
   function automatic logic [GATE_W-1:0] gate_pattern(input phase_e ph, input logic rev);
      logic [GATE_W-1:0] g;
      unique case (ph)
         PH_CHG:  g = rev ? 4'b0110 : 4'b1001;
         PH_SLOW: g = 4'b0011;
         PH_FAST: g = rev ? 4'b1001 : 4'b0110;
         default: g = '0;
      endcase
      return g;
   endfunction

   function automatic phase_e decay_entry(input decay_e m, input logic past_pt);
      phase_e p;
      unique case (m)
         DM_MIXED: p = past_pt ? PH_FAST : PH_SLOW;
         DM_SLOW:  p = PH_SLOW;
         default:  p = PH_FAST;
      endcase
      return p;
   endfunction

endpackage

// File: rtl/chop_cfg_latch.sv
`timescale 1ns/1ps
module chop_cfg_latch
   import chop_pkg::*;
#(
   parameter int BASE_LEN = 16,
   parameter int CW       = 6,
   parameter int BLK_W    = 3,
   parameter int BLANK_C0 = 2,
   parameter int BLANK_C1 = 3,
   parameter int BLANK_C2 = 4,
   parameter int BLANK_C3 = 6
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             load_i,
   input  logic [1:0]       decay_i,
   input  logic [1:0]       rate_i,
   input  logic [1:0]       mdt_i,
   input  logic [1:0]       blank_i,
   input  logic             dir_i,
   output decay_e           mode_o,
   output logic             rev_o,
   output logic [CW-1:0]    len_o,
   output logic [CW-1:0]    pt_o,
   output logic [BLK_W-1:0] blank_o
);
   localparam int LEN_BASE = BASE_LEN;
   localparam int LEN_HALF = 2 * BASE_LEN;
   localparam int LEN_TWO3 = (3 * BASE_LEN) / 2;

   decay_e     mode_q;
   logic       rev_q;
   logic [1:0] rate_q;
   logic [1:0] mdt_q;
   logic [1:0] blank_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         mode_q  <= DM_MIXED;
         rev_q   <= 1'b0;
         rate_q  <= 2'b00;
         mdt_q   <= 2'b00;
         blank_q <= 2'b00;
      end else if (load_i) begin
         mode_q  <= decay_e'(decay_i);
         rev_q   <= dir_i;
         rate_q  <= rate_i;
         mdt_q   <= mdt_i;
         blank_q <= blank_i;
      end
   end

   int k_eighths;

   always_comb begin
      unique case (rate_q)
         2'b01:   len_o = CW'(LEN_HALF);
         2'b10:   len_o = CW'(LEN_TWO3);
         default: len_o = CW'(LEN_BASE);
      endcase
      unique case (mdt_q)
         2'b00:   k_eighths = 3;
         2'b01:   k_eighths = 4;
         2'b10:   k_eighths = 2;
         default: k_eighths = 1;
      endcase
      pt_o = CW'((int'(len_o) * k_eighths) / 8);
      unique case (blank_q)
         2'b00:   blank_o = BLK_W'(BLANK_C0);
         2'b01:   blank_o = BLK_W'(BLANK_C1);
         2'b10:   blank_o = BLK_W'(BLANK_C2);
         default: blank_o = BLK_W'(BLANK_C3);
      endcase
   end

   assign mode_o = mode_q;
   assign rev_o  = rev_q;

endmodule

// File: rtl/chop_seq.sv
`timescale 1ns/1ps
module chop_seq
   import chop_pkg::*;
#(
   parameter int CW    = 6,
   parameter int BLK_W = 3
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic             trip_i,
   input  logic             band_i,
   input  decay_e           mode_i,
   input  logic [CW-1:0]    len_i,
   input  logic [CW-1:0]    pt_i,
   input  logic [BLK_W-1:0] blank_i,
   output phase_e           phase_o,
   output logic             cyc_start_o,
   output logic             load_o
);
   phase_e           phase_q, phase_d;
   logic [CW-1:0]    cnt_q, cnt_d, cnt_inc;
   logic [BLK_W-1:0] blk_q, blk_d, blk_inc;
   logic             wrap, honor;

   assign cnt_inc = cnt_q + 1'b1;
   assign blk_inc = (&blk_q) ? blk_q : blk_q + 1'b1;
   assign wrap    = (cnt_q == len_i - 1'b1);
   assign honor   = trip_i && (blk_q >= blank_i);
   assign load_o  = run_i && ((phase_q == PH_OFF) || wrap);

   always_comb begin
      phase_d = phase_q;
      cnt_d   = cnt_q;
      blk_d   = blk_q;
      if (!run_i) begin
         phase_d = PH_OFF;
         cnt_d   = '0;
         blk_d   = '0;
      end else if (phase_q == PH_OFF) begin
         phase_d = PH_CHG;
         cnt_d   = '0;
         blk_d   = BLK_W'(1);
      end else if (wrap) begin
         cnt_d = '0;
         if (mode_i == DM_AUTO && phase_q == PH_CHG) begin
            blk_d = blk_inc;
         end else if (mode_i == DM_AUTO && phase_q == PH_FAST && band_i) begin
            phase_d = PH_FAST;
         end else begin
            phase_d = PH_CHG;
            blk_d   = BLK_W'(1);
         end
      end else begin
         cnt_d = cnt_inc;
         unique case (phase_q)
            PH_CHG: begin
               if (honor) phase_d = decay_entry(mode_i, cnt_inc >= pt_i);
               else       blk_d   = blk_inc;
            end
            PH_SLOW: begin
               if (mode_i == DM_MIXED && cnt_inc >= pt_i) phase_d = PH_FAST;
            end
            PH_FAST: begin
               if (mode_i == DM_AUTO && !band_i) phase_d = PH_SLOW;
            end
            default: phase_d = PH_OFF;
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         phase_q <= PH_OFF;
         cnt_q   <= '0;
         blk_q   <= '0;
      end else begin
         phase_q <= phase_d;
         cnt_q   <= cnt_d;
         blk_q   <= blk_d;
      end
   end

   assign phase_o     = phase_q;
   assign cyc_start_o = (phase_q != PH_OFF) && (cnt_q == '0);

endmodule

// File: rtl/chop_gate_drv.sv
`timescale 1ns/1ps
module chop_gate_drv
   import chop_pkg::*;
#(
   parameter bit DEAD_EN = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              run_i,
   input  phase_e            phase_i,
   input  logic              rev_i,
   output logic [GATE_W-1:0] gate_o
);
   logic [GATE_W-1:0] tgt, gate_q;

   assign tgt = run_i ? gate_pattern(phase_i, rev_i) : '0;

   generate
      if (DEAD_EN) begin : g_dead
         logic turn_off, turn_on;
         assign turn_off = |(gate_q & ~tgt);
         assign turn_on  = |(tgt & ~gate_q);
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)                 gate_q <= '0;
            else if (turn_off && turn_on) gate_q <= '0;
            else                          gate_q <= tgt;
         end
      end else begin : g_direct
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) gate_q <= '0;
            else         gate_q <= tgt;
         end
      end
   endgenerate

   assign gate_o = gate_q;

endmodule

// File: rtl/chop_decay_ctrl.sv
`timescale 1ns/1ps
module chop_decay_ctrl
   import chop_pkg::*;
#(
   parameter int BASE_LEN = 16,
   parameter int BLANK_C0 = 2,
   parameter int BLANK_C1 = 3,
   parameter int BLANK_C2 = 4,
   parameter int BLANK_C3 = 6,
   parameter bit DEAD_EN  = 1'b1
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       run_i,
   input  logic       dir_i,
   input  logic       trip_i,
   input  logic       band_i,
   input  logic [1:0] decay_i,
   input  logic [1:0] rate_i,
   input  logic [1:0] mdt_i,
   input  logic [1:0] blank_i,
   output logic [3:0] gate_o,
   output logic [1:0] phase_o,
   output logic       cyc_start_o
);
   localparam int CW     = $clog2(2 * BASE_LEN + 1);
   localparam int BLK_A  = (BLANK_C0 > BLANK_C1) ? BLANK_C0 : BLANK_C1;
   localparam int BLK_B  = (BLANK_C2 > BLANK_C3) ? BLANK_C2 : BLANK_C3;
   localparam int BLK_TOP = (BLK_A > BLK_B) ? BLK_A : BLK_B;
   localparam int BLK_W  = $clog2(BLK_TOP + 2);

   generate
      if (BASE_LEN < 8 || (BASE_LEN % 8) != 0) begin : g_bad_len
         $error("BASE_LEN must be a positive multiple of 8");
      end
      if (BLK_TOP >= BASE_LEN) begin : g_bad_blank
         $error("blanking lengths must be shorter than the base cycle");
      end
      if (BLANK_C0 < 1 || BLANK_C1 < 1 || BLANK_C2 < 1 || BLANK_C3 < 1) begin : g_bad_blank_min
         $error("blanking lengths must be at least one clock");
      end
   endgenerate

   decay_e           mode;
   logic             rev, load;
   logic [CW-1:0]    len, pt;
   logic [BLK_W-1:0] blank;
   phase_e           phase;

   chop_cfg_latch #(
      .BASE_LEN (BASE_LEN),
      .CW       (CW),
      .BLK_W    (BLK_W),
      .BLANK_C0 (BLANK_C0),
      .BLANK_C1 (BLANK_C1),
      .BLANK_C2 (BLANK_C2),
      .BLANK_C3 (BLANK_C3)
   ) cfg_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (load),
      .decay_i (decay_i),
      .rate_i  (rate_i),
      .mdt_i   (mdt_i),
      .blank_i (blank_i),
      .dir_i   (dir_i),
      .mode_o  (mode),
      .rev_o   (rev),
      .len_o   (len),
      .pt_o    (pt),
      .blank_o (blank)
   );

   chop_seq #(
      .CW    (CW),
      .BLK_W (BLK_W)
   ) seq_i (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .run_i       (run_i),
      .trip_i      (trip_i),
      .band_i      (band_i),
      .mode_i      (mode),
      .len_i       (len),
      .pt_i        (pt),
      .blank_i     (blank),
      .phase_o     (phase),
      .cyc_start_o (cyc_start_o),
      .load_o      (load)
   );

   chop_gate_drv #(
      .DEAD_EN (DEAD_EN)
   ) drv_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .run_i   (run_i),
      .phase_i (phase),
      .rev_i   (rev),
      .gate_o  (gate_o)
   );

   assign phase_o = phase;

endmodule

// File: rtl/chop_decay_chk.sv
`timescale 1ns/1ps
module chop_decay_chk (
   input logic       clk_i,
   input logic       rst_ni,
   input logic       run_i,
   input logic [3:0] gate_o,
   input logic [1:0] phase_o,
   input logic       cyc_start_o
);
   // R12
   no_shoot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(gate_o[3] && gate_o[1]) && !(gate_o[2] && gate_o[0]));

   // R9
   dead_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (gate_o != 4'b0000) |=> (gate_o == $past(gate_o) || gate_o == 4'b0000));

   // R11
   idle_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_i |=> (gate_o == 4'b0000 && phase_o == 2'b00 && !cyc_start_o));

   // R11
   wake_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_i && phase_o == 2'b00) |=> (phase_o == 2'b01 && cyc_start_o));

   // R2
   slow_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_i && phase_o == 2'b10) |=> (phase_o != 2'b01 || cyc_start_o));

endmodule

bind chop_decay_ctrl chop_decay_chk chk_i (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .run_i       (run_i),
   .gate_o      (gate_o),
   .phase_o     (phase_o),
   .cyc_start_o (cyc_start_o)
);

// File: tb/chop_decay_ctrl_tb.sv
`timescale 1ns/1ps
module chop_decay_ctrl_tb_top;
   logic       clk = 1'b0;
   logic       rst_ni = 1'b0;
   logic       run_i = 1'b0, dir_i = 1'b0, trip_i = 1'b0, band_i = 1'b0;
   logic [1:0] decay_i = 2'b00, rate_i = 2'b00, mdt_i = 2'b00, blank_i = 2'b00;
   logic [3:0] gate_o;
   logic [1:0] phase_o;
   logic       cyc_start_o;

   int n_tests = 0;
   int n_fail  = 0;

   logic [1:0] ps [80];
   logic [3:0] gs [80];
   logic       cs [80];

   always #2.5 clk = ~clk;

   chop_decay_ctrl dut_i (
      .clk_i (clk), .rst_ni (rst_ni), .run_i (run_i), .dir_i (dir_i),
      .trip_i (trip_i), .band_i (band_i), .decay_i (decay_i), .rate_i (rate_i),
      .mdt_i (mdt_i), .blank_i (blank_i), .gate_o (gate_o), .phase_o (phase_o),
      .cyc_start_o (cyc_start_o)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int len_of(input int rate);
      return (rate == 1) ? 32 : (rate == 2) ? 24 : 16;
   endfunction

   function automatic int blank_of(input int code);
      return (code == 0) ? 2 : (code == 1) ? 3 : (code == 2) ? 4 : 6;
   endfunction

   function automatic int eighths_of(input int code);
      return (code == 0) ? 3 : (code == 1) ? 4 : (code == 2) ? 2 : 1;
   endfunction

   function automatic int count_ph(input int ph, input int from, input int upto);
      int c = 0;
      for (int i = from; i < upto; i++) if (int'(ps[i]) == ph) c++;
      return c;
   endfunction

   function automatic int next_start(input int from);
      for (int i = from; i < 80; i++) if (cs[i]) return i;
      return -1;
   endfunction

   // leave idle, then raise run; returns at the negedge showing cycle sample 0
   task automatic start_run();
      run_i = 1'b0;
      repeat (2) @(negedge clk);
      run_i = 1'b1;
      @(negedge clk);
   endtask

   task automatic capture(input int n, input int trip_at, input int rate_at, input logic [1:0] rate_new);
      for (int i = 0; i < n; i++) begin
         ps[i] = phase_o;
         gs[i] = gate_o;
         cs[i] = cyc_start_o;
         if (i == trip_at) trip_i = 1'b1;
         if (i == rate_at) rate_i = rate_new;
         @(negedge clk);
      end
   endtask

   initial begin
      #500us;
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R11", "reset gate", int'(gate_o), 0);
      chk("R11", "reset phase", int'(phase_o), 0);
      rst_ni = 1'b1;
      repeat (2) @(negedge clk);
      chk("R11", "idle cyc_start", int'(cyc_start_o), 0);

      // R1 R3 R4: slow-only sweep over chop rates and blanking codes
      for (int r = 0; r < 3; r++) begin
         for (int b = 0; b < 4; b++) begin
            decay_i = 2'b01; rate_i = 2'(r); blank_i = 2'(b); trip_i = 1'b1; dir_i = 1'b0;
            start_run();
            capture(34, -1, -1, 2'b00);
            chk("R1", $sformatf("period rate%0d", r), next_start(1), len_of(r));
            chk("R3", $sformatf("charge blank%0d rate%0d", b, r), count_ph(1, 0, len_of(r)), blank_of(b));
            chk("R4", "slow rest", count_ph(2, 0, len_of(r)), len_of(r) - blank_of(b));
         end
      end

      // R5: mixed decay point sweep
      for (int r = 0; r < 3; r++) begin
         for (int m = 0; m < 4; m++) begin
            int pt;
            pt = len_of(r) * eighths_of(m) / 8;
            decay_i = 2'b00; rate_i = 2'(r); blank_i = 2'b00; mdt_i = 2'(m); trip_i = 1'b1;
            start_run();
            capture(34, -1, -1, 2'b00);
            chk("R5", $sformatf("slow mdt%0d rate%0d", m, r), count_ph(2, 0, len_of(r)), pt - 2);
            chk("R5", $sformatf("fast mdt%0d rate%0d", m, r), count_ph(3, 0, len_of(r)), len_of(r) - pt);
         end
      end

      // R5: trip after the mixed point goes straight to fast
      decay_i = 2'b00; rate_i = 2'b00; mdt_i = 2'b00; blank_i = 2'b00; trip_i = 1'b0;
      start_run();
      capture(17, 9, -1, 2'b00);
      chk("R5", "late trip charge", count_ph(1, 0, 16), 10);
      chk("R5", "late trip slow", count_ph(2, 0, 16), 0);
      chk("R5", "late trip fast", count_ph(3, 0, 16), 6);

      // R4 R8 R9: fast-only, reverse direction, blanking 4
      decay_i = 2'b10; rate_i = 2'b00; blank_i = 2'b10; trip_i = 1'b1; dir_i = 1'b1;
      start_run();
      capture(20, -1, -1, 2'b00);
      chk("R4", "fast-only charge", count_ph(1, 0, 16), 4);
      chk("R4", "fast-only fast", count_ph(3, 0, 16), 12);
      chk("R8", "reverse charge gates", int'(gs[1]), 4'b0110);
      chk("R9", "dead clock rev", int'(gs[5]), 0);
      chk("R8", "reverse fast gates", int'(gs[6]), 4'b1001);

      // R8 R9: slow-only forward, gate patterns and dead clocks at both edges
      decay_i = 2'b01; blank_i = 2'b00; dir_i = 1'b0;
      start_run();
      capture(20, -1, -1, 2'b00);
      chk("R9", "from off direct", int'(gs[0]), 0);
      chk("R8", "forward charge gates", int'(gs[1]), 4'b1001);
      chk("R9", "dead charge->slow", int'(gs[3]), 0);
      chk("R8", "slow gates", int'(gs[4]), 4'b0011);
      chk("R8", "slow held", int'(gs[16]), 4'b0011);
      chk("R9", "dead slow->charge", int'(gs[17]), 0);
      chk("R8", "charge again", int'(gs[18]), 4'b1001);

      // R10: rate change mid-cycle applies from the next cycle
      decay_i = 2'b01; rate_i = 2'b00; blank_i = 2'b00; trip_i = 1'b1;
      start_run();
      capture(50, -1, 5, 2'b01);
      chk("R10", "current period kept", next_start(1), 16);
      chk("R10", "next period new", next_start(17) - 16, 32);

      // R11: disable mid-run and restart
      run_i = 1'b0;
      @(negedge clk);
      chk("R11", "disabled gates", int'(gate_o), 0);
      chk("R11", "disabled phase", int'(phase_o), 0);
      chk("R11", "disabled cyc_start", int'(cyc_start_o), 0);
      repeat (3) @(negedge clk);
      run_i = 1'b1;
      @(negedge clk);
      chk("R11", "restart phase", int'(phase_o), 1);
      chk("R11", "restart cyc_start", int'(cyc_start_o), 1);

      // R6 R7: adaptive stretching of charge and fast across boundaries
      decay_i = 2'b11; rate_i = 2'b00; blank_i = 2'b00; trip_i = 1'b0; band_i = 1'b0;
      start_run();
      for (int i = 0; i < 64; i++) begin
         int ex;
         if (i <= 20)      ex = 1;
         else if (i <= 39) ex = 3;
         else if (i <= 47) ex = 2;
         else if (i <= 49) ex = 1;
         else if (i == 50) ex = 3;
         else              ex = 2;
         chk((i <= 20 || i >= 48) ? "R6" : "R7", $sformatf("adaptive phase @%0d", i), int'(phase_o), ex);
         if ((i % 16) == 0) chk("R1", $sformatf("adaptive boundary @%0d", i), int'(cyc_start_o), 1);
         trip_i = (i >= 20);
         band_i = (i >= 20 && i < 39);
         @(negedge clk);
      end

      run_i = 1'b0;
      @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule